// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Controller

This block turns simple requests into command sequences for a DRAM-style memory. Each request carries a full address, a read or write flag and a burst length. The memory has one shared set of address pins: a row strobe marks the cycle in which the pins carry a row number, and a column strobe marks each cycle in which they carry a column number. The controller remembers which row is open. A request to that row goes straight to column accesses. A request to another row first closes the open row, which writes the row's latched contents back into the array, and then opens the new row.

A burst reads or writes consecutive columns, one per clock, inside a single row. The request address is split as {row, column}, with the column in the low bits. The burst length field holds the number of beats minus one. Write data is taken from the write-data input in each cycle in which the write-take output is high. Read data returns with a valid flag, one beat per column and in column order. A free-running interval timer raises a refresh request. The refresh is serviced only between accesses: the controller closes any open row and then issues one refresh strobe.

Top module: `mux_dram_ctrl`

## Requirements
- R1: After reset no memory strobe is active, reqReady is high, rdValid and wrTake are low, and no row is open, so the first access starts with a row strobe.
- R2: A request while no row is open gives a row strobe with the row number on memAddr in the cycle after acceptance, and the first column strobe follows T_RCD cycles after that row strobe (latency 1+T_RCD from the accept cycle).
- R3: A request whose row equals the open row issues its first column strobe in the cycle right after acceptance, with no row or precharge strobe in between.
- R4: A request to a row other than the open one gives a precharge strobe in the cycle after acceptance, then a row strobe T_RP cycles later, and its first column strobe at 1+T_RP+T_RCD cycles after acceptance.
- R5: A burst with length field L produces L+1 column strobes on consecutive cycles, with the column on memAddr rising by one each beat and the open row unchanged.
- R6: A burst that passes the last column wraps to column 0 of the same row.
- R7: Each read column strobe yields exactly one rdValid pulse T_CL cycles later, carrying the word stored at that row and column. Pulses come in burst order.
- R8: During write beats, memWe and wrTake are high together, and memWData carries wrData. Outside column strobes, wrTake is low.
- R9: A refresh request is raised every REF_INTERVAL cycles. It is served only while no burst is running. When a row is open it is closed first, and a refresh strobe is never issued while a row is open. With no traffic, refresh strobes are exactly REF_INTERVAL cycles apart. After a refresh, the next access must open its row again.
- R10: A pending refresh takes priority over a waiting request (reqReady stays low), but never breaks into a burst. Under continuous traffic, consecutive refresh strobes are at most REF_INTERVAL plus one complete access and one precharge apart.
- R11: At most one of the row, column, precharge and refresh strobes is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle when reqValid is high |
| reqWrite | input | 1 | 1 = write burst, 0 = read burst |
| reqAddr | input | ROW_W+COL_W | {row, column} start address |
| reqLen | input | LEN_W | Beats minus one |
| wrData | input | DATA_W | Write word for the current write beat |
| wrTake | output | 1 | wrData is consumed at this clock edge |
| rdValid | output | 1 | rdData holds a read beat |
| rdData | output | DATA_W | Read word |
| memAddr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| memRowStb | output | 1 | Open row (pins hold row) |
| memColStb | output | 1 | Column access (pins hold column) |
| memPreStb | output | 1 | Close the open row |
| memRefStb | output | 1 | Refresh one row |
| memWe | output | 1 | Column access is a write |
| memWData | output | DATA_W | Data to memory |
| memRData | input | DATA_W | Data from memory, T_CL cycles after a read column strobe |

## Verification
The hardest case to reach is a refresh that becomes due in the middle of a burst, or while a miss is already running its precharge and activation. The refresh must then wait for the access to finish and must still close the newly opened row. Uniform random traffic rarely lines these up. The stimulus therefore issues requests back to back over a few hundred random bursts, with rows drawn from a small set and lengths up to the maximum, so that the refresh timer keeps expiring during accesses. A memory model in the bench rejects any column access to a closed row and any refresh while a row is open. It also bounds the gap between refreshes under this load.

// File: rtl/mdc_pkg.sv
package mdc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_BURST,
    ST_REF
  } mdcState_e;

  // strobes from control to datapath
  typedef struct packed {
    mdcState_e phase;     // current phase, selects the hold count
    logic      phaseClr;  // phase changes at this edge
    logic      take;      // latch the request
    logic      rowStb;
    logic      colStb;
    logic      preStb;
    logic      refStb;
  } mdcCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic rowHit;
    logic openValid;
    logic phaseDone;
    logic lastBeat;
    logic refPending;
  } mdcStat_t;

endpackage

// File: rtl/mdc_ctrl.sv
module mdc_ctrl
  import mdc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  mdcStat_t stat,
  output logic     reqReady,
  output mdcCmd_t  cmd
);

  mdcState_e state, nextState;
  logic preForRef, preForRefNext;
  logic entered;

  always_comb begin
    nextState     = state;
    preForRefNext = preForRef;
    case (state)
      ST_IDLE: begin
        if (stat.refPending) begin
          preForRefNext = 1'b1;
          nextState     = stat.openValid ? ST_PRE : ST_REF;
        end else if (reqValid) begin
          preForRefNext = 1'b0;
          if (stat.rowHit)         nextState = ST_BURST;
          else if (stat.openValid) nextState = ST_PRE;
          else                     nextState = ST_ACT;
        end
      end
      ST_PRE:   if (stat.phaseDone) nextState = preForRef ? ST_REF : ST_ACT;
      ST_ACT:   if (stat.phaseDone) nextState = ST_BURST;
      ST_BURST: if (stat.lastBeat)  nextState = ST_IDLE;
      ST_REF:   if (stat.phaseDone) nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      preForRef <= 1'b0;
      entered   <= 1'b0;
    end else begin
      state     <= nextState;
      preForRef <= preForRefNext;
      entered   <= (nextState != state);
    end
  end

  assign reqReady = (state == ST_IDLE) && !stat.refPending;

  always_comb begin
    cmd.phase    = state;
    cmd.phaseClr = (nextState != state);
    cmd.take     = reqReady && reqValid;
    cmd.rowStb   = (state == ST_ACT) && entered;
    cmd.preStb   = (state == ST_PRE) && entered;
    cmd.refStb   = (state == ST_REF) && entered;
    cmd.colStb   = (state == ST_BURST);
  end

  // R10: a burst runs to its last beat without interruption
  assert_burst_uninterrupted_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BURST && !stat.lastBeat) |=> (state == ST_BURST));

  // R9: refresh strobe only with every row closed
  assert_ref_rows_closed_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.refStb |-> !stat.openValid);

endmodule

// File: rtl/mdc_datapath.sv
module mdc_datapath
  import mdc_pkg::*;
#(
  parameter int ROW_W        = 4,
  parameter int COL_W        = 4,
  parameter int LEN_W        = 3,
  parameter int T_RCD        = 2,
  parameter int T_RP         = 2,
  parameter int T_CL         = 2,
  parameter int T_RFC        = 3,
  parameter int REF_INTERVAL = 64,
  localparam int ADDR_W      = ROW_W + COL_W,
  localparam int PIN_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdcCmd_t           cmd,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output mdcStat_t          stat,
  output logic [PIN_W-1:0]  memAddr,
  output logic              memWe,
  output logic              rdValid
);

  localparam int MAX_T = (T_RCD > T_RP) ? ((T_RCD > T_RFC) ? T_RCD : T_RFC)
                                        : ((T_RP > T_RFC) ? T_RP : T_RFC);
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam int REF_W = $clog2(REF_INTERVAL + 1);

  logic [ROW_W-1:0] latRow, openRow;
  logic             openValid, latWe;
  logic [COL_W-1:0] colCur;
  logic [LEN_W-1:0] beatsLeft;
  logic [CNT_W-1:0] phaseCnt, phaseLim;
  logic [REF_W-1:0] refCnt;
  logic             refPending, refWrap;
  logic [T_CL-1:0]  rdPipe;
  logic             rdIn;

  // request capture, open-row tracking, burst stepping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latRow    <= '0;
      latWe     <= 1'b0;
      colCur    <= '0;
      beatsLeft <= '0;
      openRow   <= '0;
      openValid <= 1'b0;
    end else begin
      if (cmd.take) begin
        latRow    <= reqAddr[ADDR_W-1:COL_W];
        colCur    <= reqAddr[COL_W-1:0];
        beatsLeft <= reqLen;
        latWe     <= reqWrite;
      end else if (cmd.colStb) begin
        colCur    <= colCur + 1'b1;   // wraps inside the row
        beatsLeft <= beatsLeft - 1'b1;
      end
      if (cmd.rowStb) begin
        openRow   <= latRow;
        openValid <= 1'b1;
      end else if (cmd.preStb) begin
        openValid <= 1'b0;
      end
    end
  end

  // phase hold counter
  always_comb begin
    case (cmd.phase)
      ST_PRE:  phaseLim = CNT_W'(T_RP - 1);
      ST_ACT:  phaseLim = CNT_W'(T_RCD - 1);
      ST_REF:  phaseLim = CNT_W'(T_RFC - 1);
      default: phaseLim = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       phaseCnt <= '0;
    else if (cmd.phaseClr)           phaseCnt <= '0;
    else if (phaseCnt != phaseLim)   phaseCnt <= phaseCnt + 1'b1;
  end

  // free-running refresh interval timer
  assign refWrap = (refCnt == REF_W'(REF_INTERVAL - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt     <= '0;
      refPending <= 1'b0;
    end else begin
      refCnt <= refWrap ? '0 : refCnt + 1'b1;
      if (cmd.refStb) refPending <= 1'b0;
      if (refWrap)    refPending <= 1'b1;
    end
  end

  // read-latency delay line
  assign rdIn = cmd.colStb && !latWe;

  generate
    if (T_CL == 1) begin : g_clOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) rdPipe <= '0;
        else       rdPipe <= rdIn;
      end
    end else begin : g_clMany
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) rdPipe <= '0;
        else       rdPipe <= {rdPipe[T_CL-2:0], rdIn};
      end
    end
  endgenerate

  assign rdValid = rdPipe[T_CL-1];

  // shared address pins
  always_comb begin
    if (cmd.rowStb)      memAddr = PIN_W'(latRow);
    else if (cmd.colStb) memAddr = PIN_W'(colCur);
    else                 memAddr = '0;
  end

  assign memWe = cmd.colStb && latWe;

  assign stat.rowHit     = openValid && (reqAddr[ADDR_W-1:COL_W] == openRow);
  assign stat.openValid  = openValid;
  assign stat.phaseDone  = (phaseCnt == phaseLim);
  assign stat.lastBeat   = (beatsLeft == '0);
  assign stat.refPending = refPending;

  // R3: column access only into the row the burst belongs to
  assert_col_in_open_row_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.colStb |-> (openValid && openRow == latRow));

  // R4: precharge leaves no row open
  assert_pre_closes_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.preStb |=> !openValid);

  // R2: a row is opened only when none is open
  assert_act_when_closed_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.rowStb |-> !openValid);

endmodule

// File: rtl/mux_dram_ctrl.sv
module mux_dram_ctrl
  import mdc_pkg::*;
#(
  parameter int ROW_W        = 4,
  parameter int COL_W        = 4,
  parameter int DATA_W       = 16,
  parameter int LEN_W        = 3,
  parameter int T_RCD        = 2,
  parameter int T_RP         = 2,
  parameter int T_CL         = 2,
  parameter int T_RFC        = 3,
  parameter int REF_INTERVAL = 64,
  localparam int ADDR_W      = ROW_W + COL_W,
  localparam int PIN_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrTake,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [PIN_W-1:0]  memAddr,
  output logic              memRowStb,
  output logic              memColStb,
  output logic              memPreStb,
  output logic              memRefStb,
  output logic              memWe,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData
);

  mdcCmd_t  cmd;
  mdcStat_t stat;

  mdc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .stat     (stat),
    .reqReady (reqReady),
    .cmd      (cmd)
  );

  mdc_datapath #(
    .ROW_W        (ROW_W),
    .COL_W        (COL_W),
    .LEN_W        (LEN_W),
    .T_RCD        (T_RCD),
    .T_RP         (T_RP),
    .T_CL         (T_CL),
    .T_RFC        (T_RFC),
    .REF_INTERVAL (REF_INTERVAL)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqLen   (reqLen),
    .stat     (stat),
    .memAddr  (memAddr),
    .memWe    (memWe),
    .rdValid  (rdValid)
  );

  assign memRowStb = cmd.rowStb;
  assign memColStb = cmd.colStb;
  assign memPreStb = cmd.preStb;
  assign memRefStb = cmd.refStb;
  assign wrTake    = memWe;
  assign memWData  = wrData;
  assign rdData    = memRData;

endmodule

// File: tb/mux_dram_ctrl_tb_top.sv
`timescale 1ns/1ps
module mux_dram_ctrl_tb_top;

  localparam int ROW_W = 4, COL_W = 4, DATA_W = 16, LEN_W = 3;
  localparam int T_RCD = 2, T_RP = 2, T_CL = 2, T_RFC = 3, RI = 64;
  localparam int SLACK = T_RP + T_RCD + (1 << LEN_W) + T_RP + 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [7:0] reqAddr = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic [DATA_W-1:0] wrData, rdData, memWData, memRData;
  logic reqReady, wrTake, rdValid, memRowStb, memColStb, memPreStb, memRefStb, memWe;
  logic [3:0] memAddr;

  always #2.5 clk = ~clk;

  mux_dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_CL(T_CL), .T_RFC(T_RFC), .REF_INTERVAL(RI)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqLen(reqLen), .wrData(wrData),
    .wrTake(wrTake), .rdValid(rdValid), .rdData(rdData), .memAddr(memAddr),
    .memRowStb(memRowStb), .memColStb(memColStb), .memPreStb(memPreStb),
    .memRefStb(memRefStb), .memWe(memWe), .memWData(memWData), .memRData(memRData));

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int i);
    return DATA_W'(i * 977 + 23);
  endfunction

  // write data source
  int wIdx = 0;
  assign wrData = pat(wIdx);
  always @(posedge clk) if (wrTake) wIdx <= wIdx + 1;

  // memory model
  logic [DATA_W-1:0] arr [256];
  logic [DATA_W-1:0] refMem [256];
  logic [DATA_W-1:0] mPipe [T_CL];
  logic [3:0] mRowP;
  initial for (int i = 0; i < 256; i++) begin arr[i] = '0; refMem[i] = '0; end
  assign memRData = mPipe[T_CL-1];
  always @(posedge clk) begin
    if (memRowStb) mRowP <= memAddr;
    if (memColStb && memWe) arr[{mRowP, memAddr}] <= memWData;
    mPipe[0] <= (memColStb && !memWe) ? arr[{mRowP, memAddr}] : '0;
    for (int i = 1; i < T_CL; i++) mPipe[i] <= mPipe[i-1];
  end

  // monitor
  int cyc = 0, actCyc = -100, preCyc = -100, lastRef = -1, lastColCyc = 0, refCount = 0;
  int accCyc = 0, expLat = 0, bLen = 0, bIdx = 0, wSeen = 0;
  bit mOpen = 0, bWrite = 0, idlePhase = 0;
  logic [3:0] mRow = '0, bRow = '0, bCol = '0;
  string latTag = "R2";
  logic [DATA_W-1:0] expQ[$];
  int expT[$];

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if ((memRowStb + memColStb + memPreStb + memRefStb) > 1)
        chk(0, "R11", memRowStb + memColStb + memPreStb + memRefStb, 1);
      if (memRowStb) begin
        chk(!mOpen, "R2 act on closed", mOpen, 0);
        chk(cyc - preCyc >= T_RP, "R4 precharge time", cyc - preCyc, T_RP);
        mOpen = 1; mRow = memAddr; actCyc = cyc;
      end
      if (memPreStb) begin
        chk(mOpen, "R4 precharge of open row", mOpen, 1);
        mOpen = 0; preCyc = cyc;
      end
      if (memRefStb) begin
        refCount++;
        chk(!mOpen, "R9 refresh with row open", mOpen, 0);
        if (lastRef >= 0) begin
          if (idlePhase) chk(cyc - lastRef == RI, "R9 idle refresh gap", cyc - lastRef, RI);
          else chk(cyc - lastRef <= RI + SLACK, "R10 refresh gap", cyc - lastRef, RI + SLACK);
        end
        lastRef = cyc;
      end
      if (memColStb) begin
        chk(mOpen, "R3 column on open row", mOpen, 1);
        chk(cyc - actCyc >= T_RCD, "R2 row-to-column", cyc - actCyc, T_RCD);
        chk(mRow == bRow, "R5 row kept", mRow, bRow);
        chk(memAddr == 4'(bCol + bIdx), "R6 column sequence", memAddr, 4'(bCol + bIdx));
        if (bIdx == 0) chk(cyc - accCyc == expLat, latTag, cyc - accCyc, expLat);
        else chk(cyc == lastColCyc + 1, "R5 consecutive beats", cyc - lastColCyc, 1);
        chk(bIdx <= bLen, "R5 beat count", bIdx, bLen);
        chk(wrTake == bWrite && memWe == bWrite, "R8 write flags", wrTake, bWrite);
        if (bWrite) begin
          chk(memWData == pat(wSeen), "R8 write data", memWData, pat(wSeen));
          refMem[{mRow, memAddr}] = pat(wSeen);
          wSeen++;
        end else begin
          expQ.push_back(refMem[{mRow, memAddr}]);
          expT.push_back(cyc + T_CL);
        end
        lastColCyc = cyc; bIdx++;
      end else if (wrTake) chk(0, "R8 wrTake outside beat", 1, 0);
      if (rdValid) begin
        if (expQ.size() == 0) chk(0, "R7 unexpected read", 1, 0);
        else begin
          logic [DATA_W-1:0] e;
          int t;
          e = expQ.pop_front(); t = expT.pop_front();
          chk(cyc == t, "R7 read latency", cyc, t);
          chk(rdData == e, "R7 read data", rdData, e);
        end
      end
      if (reqValid && reqReady) begin
        if (bIdx != bLen + 1 && accCyc != 0) chk(0, "R5 burst length", bIdx, bLen + 1);
        accCyc = cyc; bRow = reqAddr[7:4]; bCol = reqAddr[3:0];
        bLen = reqLen; bIdx = 0; bWrite = reqWrite;
        if (mOpen && mRow == bRow) begin expLat = 1; latTag = "R3 hit latency"; end
        else if (mOpen) begin expLat = 1 + T_RP + T_RCD; latTag = "R4 miss latency"; end
        else begin expLat = 1 + T_RCD; latTag = "R2 closed latency"; end
      end
    end
  end

  task automatic issue(input bit w, input logic [3:0] row, input logic [3:0] col,
                       input logic [LEN_W-1:0] len);
    @(posedge clk); #1;
    reqValid = 1; reqWrite = w; reqAddr = {row, col}; reqLen = len;
    forever begin
      @(negedge clk); #1;
      if (reqReady) break;
    end
    @(posedge clk); #1;
    reqValid = 0;
  endtask

  bit wdFired = 0;

  initial begin
    void'($urandom(32'd4711));
    fork
      begin
        repeat (5) @(negedge clk);
        rstN = 1;
        @(negedge clk); #1;
        // R1: reset state
        chk(reqReady, "R1 reqReady", reqReady, 1);
        chk(!(memRowStb | memColStb | memPreStb | memRefStb), "R1 strobes", memColStb, 0);
        chk(!rdValid && !wrTake, "R1 rdValid/wrTake", rdValid, 0);
        idlePhase = 1;
        repeat (3 * RI + 4) @(negedge clk);
        idlePhase = 0;
        chk(refCount == 3, "R9 idle refresh count", refCount, 3);
        // directed corners
        issue(1, 4'd2, 4'd0, 3'd3);   // closed row
        issue(0, 4'd2, 4'd0, 3'd3);   // hit
        issue(1, 4'd5, 4'd14, 3'd7);  // miss, wraps
        issue(0, 4'd5, 4'd14, 3'd7);  // hit, wraps
        issue(0, 4'd2, 4'd1, 3'd0);   // miss, single beat
        // random back-to-back traffic
        for (int n = 0; n < 400; n++)
          issue($urandom % 2, 4'($urandom % 4), 4'($urandom), 3'($urandom));
        repeat (30) @(negedge clk);
        chk(expQ.size() == 0, "R7 reads outstanding", expQ.size(), 0);
        chk(refCount > 3, "R10 refresh under load", refCount, 4);
      end
      begin
        repeat (150000) @(posedge clk);
        wdFired = 1;
      end
    join_any
    disable fork;
    if (wdFired) begin
      checks++; failures++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule